// File: doc/BRIEF.md
# Timer input capture channel

This block is a single channel of a timer that records when an external signal changes. The input pin is brought into the clock domain and filtered. A selected edge of the filtered level then freezes the value of a free-running counter, which the block receives from outside. The frozen value lands first in an internal holding (shadow) register. One cycle later it is copied into the capture register that software sees.

Each capture raises a capture flag. It can also emit a one-cycle interrupt request pulse and a one-cycle DMA request pulse, each behind its own enable bit. A capture that arrives while the flag is still up also raises an over-capture flag. Software uses a small register port to configure the channel, read the captured value and acknowledge the flags. Reading the capture register acknowledges the capture flag.

Top module: `tcap_channel`

## Requirements
- R1: After synchronous reset, the capture register, the control register (address 1) and the status register (address 2) read 0, and both request pulses are low.
- R2: Control register bit layout: bits 1:0 are the mode, bit 2 is the edge polarity, bit 3 is the capture enable, bits 7:4 are the filter length, bit 8 is the interrupt enable and bit 9 is the DMA enable. Reads return the written value. With mode 00 (output), software writes to the capture register (address 0) take effect.
- R3: With any non-zero mode the channel is an input, and software writes to the capture register leave its value unchanged.
- R4: With mode 01 and capture enable set, a selected input edge makes the capture register hold the counter value sampled on the (F+4)-th clock edge after the input changes, where F is the filter length.
- R5: Polarity 0 captures on rising edges of the filtered input only. Polarity 1 captures on falling edges only.
- R6: The filter accepts a new level only after F+1 consecutive samples at that level. F=0 means no filtering. A shorter pulse causes no capture.
- R7: Each capture sets status bit 0 (capture flag) one edge after the capture edge. On that same edge the interrupt pulse rises for one cycle if the interrupt enable is set, and the DMA pulse rises for one cycle if the DMA enable is set.
- R8: A capture while the capture flag is already set also sets status bit 1 (over-capture flag).
- R9: Writing status bits clears each bit written as 0 and leaves each bit written as 1 unchanged. Reading the capture register clears the capture flag. The over-capture flag is cleared only by a write.
- R10: If a read of the capture register falls on the same edge that a new capture sets the flag, the flag stays set and the new value is stored.
- R11: With capture enable clear, or with mode 10 or 11, input edges cause no capture and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CNT_W | Free-running counter value |
| cap_in | input | 1 | Asynchronous capture input |
| bus_addr | input | 2 | Register address: 0 capture, 1 control, 2 status |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr, combinational |
| irq_pulse | output | 1 | One-cycle interrupt request |
| dma_pulse | output | 1 | One-cycle DMA request |

## Verification
The assertions assume three things about the inputs. Reset is applied before the first check. Bus strobes last one cycle and never combine a read and a write. The capture input may be fully asynchronous, because only the synchronised and filtered copy feeds any property. The bench changes every input on the falling clock edge, issues one bus access at a time, and holds the capture input long enough for each expected capture to finish before the next access. The one exception is the deliberate collision of R10, which is timed to the exact update edge.

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [1:0] {
        MODE_OUT  = 2'b00,
        MODE_IN1  = 2'b01,
        MODE_RSV2 = 2'b10,
        MODE_RSV3 = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        ADR_CAPT = 2'd0,
        ADR_CTRL = 2'd1,
        ADR_STAT = 2'd2,
        ADR_NONE = 2'd3
    } addr_e;

    // Packed MSB first: de is bit 9, mode occupies bits 1:0
    typedef struct packed {
        logic       de;
        logic       ie;
        logic [3:0] flt;
        logic       cen;
        logic       pol;
        mode_e      mode;
    } ctrl_t;

    typedef struct packed {
        logic ovf;
        logic flag;
    } stat_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int STAT_W = $bits(stat_t);

    function automatic logic is_input(mode_e m);
        return m != MODE_OUT;
    endfunction

    function automatic logic edge_hit(logic pol, logic prev, logic cur);
        return pol ? (prev & ~cur) : (cur & ~prev);
    endfunction

endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/tcap_filter.sv
module tcap_filter #(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             d,
    input  logic [LEN_W-1:0] len,
    output logic             q
);
    logic [LEN_W-1:0] run;

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= 1'b0;
            run <= '0;
        end else if (d == q) begin
            run <= '0;
        end else if (run >= len) begin
            q   <= d;
            run <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end

    AST_FLT_TAKES_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        !$stable(q) |-> (q == $past(d))); // R6

    AST_FLT_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        (!$stable(q) && $past(len) != '0) |-> ($past(q) == $past(q, 2))); // R6
endmodule

// File: rtl/tcap_detect.sv
module tcap_detect
    import tcap_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic pol,
    output logic hit
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl;
    end

    assign hit = edge_hit(pol, prev, lvl);

    AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (rst)
        hit |-> (lvl != prev)); // R5
endmodule

// File: rtl/tcap_channel.sv
module tcap_channel
    import tcap_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FLT_W       = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cap_in,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq_pulse,
    output logic             dma_pulse
);
    localparam int DW = CNT_W;

    ctrl_t          ctrl_q;
    stat_t          stat_q;
    logic [DW-1:0]  shadow_q;
    logic [DW-1:0]  preload_q;
    logic           upd_q;
    logic           s_lvl;
    logic           f_lvl;
    logic           hit;
    logic           cap_ev;
    logic           wr_capt;
    logic           wr_ctrl;
    logic           wr_stat;
    logic           rd_capt;
    addr_e          adr;

    tcap_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (cap_in),
        .q   (s_lvl)
    );

    tcap_filter #(.LEN_W(FLT_W)) i_filter (
        .clk (clk),
        .rst (rst),
        .d   (s_lvl),
        .len (ctrl_q.flt),
        .q   (f_lvl)
    );

    tcap_detect i_detect (
        .clk (clk),
        .rst (rst),
        .lvl (f_lvl),
        .pol (ctrl_q.pol),
        .hit (hit)
    );

    assign adr     = addr_e'(bus_addr);
    assign cap_ev  = hit && ctrl_q.cen && (ctrl_q.mode == MODE_IN1);
    assign wr_capt = bus_wr && (adr == ADR_CAPT) && !is_input(ctrl_q.mode);
    assign wr_ctrl = bus_wr && (adr == ADR_CTRL);
    assign wr_stat = bus_wr && (adr == ADR_STAT);
    assign rd_capt = bus_rd && (adr == ADR_CAPT);

    // Capture path: counter into shadow, then shadow into preload
    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            upd_q    <= 1'b0;
        end else begin
            upd_q <= cap_ev;
            if (cap_ev) shadow_q <= cnt_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          preload_q <= '0;
        else if (upd_q)   preload_q <= shadow_q;
        else if (wr_capt) preload_q <= bus_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
    end

    // Status flags: a new capture always beats a clear
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
        end else begin
            if (upd_q)
                stat_q.flag <= 1'b1;
            else if (rd_capt || (wr_stat && !bus_wdata[0]))
                stat_q.flag <= 1'b0;

            if (upd_q && stat_q.flag)
                stat_q.ovf <= 1'b1;
            else if (wr_stat && !bus_wdata[1])
                stat_q.ovf <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pulse <= 1'b0;
            dma_pulse <= 1'b0;
        end else begin
            irq_pulse <= upd_q && ctrl_q.ie;
            dma_pulse <= upd_q && ctrl_q.de;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (adr)
            ADR_CAPT: bus_rdata = preload_q;
            ADR_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
            ADR_STAT: bus_rdata[STAT_W-1:0] = stat_q;
            default:  bus_rdata = '0;
        endcase
    end

    AST_FLAG_AFTER_UPD: assert property (@(posedge clk) disable iff (rst)
        upd_q |=> stat_q.flag); // R7

    AST_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (irq_pulse || dma_pulse) |-> stat_q.flag); // R7

    AST_OVF_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_q.ovf) |-> $past(stat_q.flag)); // R8

    AST_RO_IN_INPUT: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && adr == ADR_CAPT && ctrl_q.mode != MODE_OUT && !upd_q)
        |=> $stable(preload_q)); // R3

    AST_READ_LOSES: assert property (@(posedge clk) disable iff (rst)
        (upd_q && rd_capt) |=> stat_q.flag); // R10

    AST_NO_CAP_DISABLED: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.cen || ctrl_q.mode != MODE_IN1) |=> !upd_q); // R11
endmodule

// File: tb/test_tcap_channel.sv
`timescale 1ns/1ps
module test_tcap_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cnt;
    logic        cap_in = 1'b0;
    logic [1:0]  bus_addr = 2'd3;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq_pulse;
    logic        dma_pulse;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [15:0] cyc;
        logic        irq;
        logic        dma;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 16'd1;
    end

    tcap_channel i_tcap_channel (
        .clk       (clk),
        .rst       (rst),
        .cnt_val   (cnt),
        .cap_in    (cap_in),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_pulse (irq_pulse),
        .dma_pulse (dma_pulse)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 2'd3;
    endtask

    task automatic rd(logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 2'd3;
    endtask

    // Driver: change the input, push the expected request into the scoreboard
    task automatic drive(logic val, int k, logic push, logic irq, logic dma,
                         output logic [15:0] exp_val);
        logic [15:0] v;
        @(negedge clk);
        cap_in = val;
        v = cnt;
        exp_val = v + 16'(k + 2);
        if (push) sb.push_back('{cyc: v + 16'(k + 4), irq: irq, dma: dma});
        idle(k + 8);
        chk("R7 pending requests", 16'(sb.size()), 16'd0);
    endtask

    // Monitor: every request pulse must match the scoreboard head
    always @(negedge clk) begin
        if (!rst && (irq_pulse || dma_pulse)) begin
            if (sb.size() == 0) begin
                chk("R7 unexpected pulse", {14'd0, dma_pulse, irq_pulse}, 16'd0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk("R4 pulse cycle", cnt, e.cyc);
                chk("R7 pulse kind", {14'd0, dma_pulse, irq_pulse}, {14'd0, e.dma, e.irq});
            end
        end
    end

    initial begin
        #500000;
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] e;
        logic [15:0] e2;
        logic [15:0] v;

        idle(4);
        rst = 1'b0;
        idle(1);
        // R1
        chk("R1 pulses", {14'd0, dma_pulse, irq_pulse}, 16'd0);
        rd(2'd0, d); chk("R1 capture reset", d, 16'h0000);
        rd(2'd1, d); chk("R1 control reset", d, 16'h0000);
        rd(2'd2, d); chk("R1 status reset", d, 16'h0000);

        // R2: output mode, capture register writable; control readback
        wr(2'd0, 16'hBEEF);
        rd(2'd0, d); chk("R2 write in output mode", d, 16'hBEEF);
        wr(2'd1, 16'h03F4);
        rd(2'd1, d); chk("R2 control readback", d, 16'h03F4);

        // input mode 01, cen, ie, de, pol 0, F=0
        wr(2'd1, 16'h0309);
        wr(2'd0, 16'h1234);
        rd(2'd0, d); chk("R3 write ignored in input", d, 16'hBEEF);

        // R4, R7: rising edge capture
        drive(1'b1, 1, 1'b1, 1'b1, 1'b1, e);
        rd(2'd2, d); chk("R7 flag set", d, 16'h0001);
        rd(2'd0, d); chk("R4 captured value", d, e);
        rd(2'd2, d); chk("R9 read clears flag", d, 16'h0000);

        // R5: falling edge ignored with pol 0
        drive(1'b0, 1, 1'b0, 1'b0, 1'b0, e2);
        rd(2'd2, d); chk("R5 falling ignored", d, 16'h0000);
        rd(2'd0, d); chk("R5 value kept", d, e);

        // R5: pol 1
        wr(2'd1, 16'h030D);
        drive(1'b1, 1, 1'b0, 1'b0, 1'b0, e2);
        rd(2'd2, d); chk("R5 rising ignored pol1", d, 16'h0000);
        drive(1'b0, 1, 1'b1, 1'b1, 1'b1, e);
        rd(2'd0, d); chk("R5 falling captured", d, e);

        // R6: filter F=7 rejects 5-cycle glitch, accepts steady level
        wr(2'd1, 16'h0179);
        @(negedge clk); cap_in = 1'b1;
        idle(5);
        cap_in = 1'b0;
        idle(15);
        rd(2'd2, d); chk("R6 glitch rejected", d, 16'h0000);
        drive(1'b1, 8, 1'b1, 1'b1, 1'b0, e);
        rd(2'd0, d); chk("R6 filtered capture", d, e);

        // R8, R9: over-capture and write-zero clearing
        wr(2'd1, 16'h0209);
        drive(1'b0, 1, 1'b0, 1'b0, 1'b0, e2);
        drive(1'b1, 1, 1'b1, 1'b0, 1'b1, e2);
        drive(1'b0, 1, 1'b0, 1'b0, 1'b0, e2);
        drive(1'b1, 1, 1'b1, 1'b0, 1'b1, e);
        rd(2'd2, d); chk("R8 overcapture", d, 16'h0003);
        wr(2'd2, 16'h0003);
        rd(2'd2, d); chk("R9 write ones no effect", d, 16'h0003);
        wr(2'd2, 16'h0002);
        rd(2'd2, d); chk("R9 clear flag keep ovf", d, 16'h0002);
        rd(2'd0, d); chk("R8 latest value", d, e);
        rd(2'd2, d); chk("R9 read keeps ovf", d, 16'h0002);
        wr(2'd2, 16'h0001);
        rd(2'd2, d); chk("R9 clear ovf", d, 16'h0000);

        // R10: read on the same edge as the update
        wr(2'd1, 16'h0109);
        drive(1'b0, 1, 1'b0, 1'b0, 1'b0, e2);
        @(negedge clk);
        cap_in = 1'b1;
        v = cnt;
        sb.push_back('{cyc: v + 16'd5, irq: 1'b1, dma: 1'b0});
        idle(4);
        bus_addr = 2'd0; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 2'd3;
        idle(6);
        rd(2'd2, d); chk("R10 flag survives read", d, 16'h0001);
        rd(2'd0, d); chk("R10 new value stored", d, v + 16'd3);

        // R11: capture enable off, then reserved mode
        wr(2'd1, 16'h0101);
        drive(1'b0, 1, 1'b0, 1'b0, 1'b0, e2);
        drive(1'b1, 1, 1'b0, 1'b0, 1'b0, e2);
        rd(2'd2, d); chk("R11 cen off no capture", d, 16'h0000);
        wr(2'd1, 16'h010A);
        drive(1'b0, 1, 1'b0, 1'b0, 1'b0, e2);
        drive(1'b1, 1, 1'b0, 1'b0, 1'b0, e2);
        rd(2'd2, d); chk("R11 mode 10 no capture", d, 16'h0000);
        wr(2'd0, 16'h5555);
        rd(2'd0, d); chk("R3 mode 10 read-only", d, v + 16'd3);

        idle(4);
        chk("R7 scoreboard drained", 16'(sb.size()), 16'd0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule